// File: doc/BRIEF.md
# Interrupt Queue and Dispatch Controller

This block sits beside a small processor core and owns everything about interrupt delivery except the register and stack work the core does itself. Hardware interrupt messages and software-raised interrupts enter one first-in first-out queue of 16-bit messages. Entry is gated by a handler-address register, and removal is gated by a hold word. The core reports its instruction boundaries, its return-from-interrupt instruction, and writes to the hold word and the address register. In return, the block raises a one-cycle entry pulse that carries the message and the handler address.

The hold word is read at any time on its own output. A swap operation loads a new value and, in the same cycle, shows the old value on that output. Nested hold sections can save and restore the word this way. Entering a handler forces the hold word to one. Returning clears it, and when the queue still holds work the next handler is entered straight away without any ordinary instruction in between. Software interrupts raised while the hold word is nonzero wait in the queue like any others. The block does not tell an interrupt source when its message is dispatched. A queue overflow halts the block permanently through a halt output.

The controller is a three-state machine. USER means ordinary code is running. HANDLER means a handler is running. HALT means the queue has overflowed. The transitions are: ENTER (USER to HANDLER, on a boundary with the hold word zero and the queue non-empty), CHAIN (HANDLER to HANDLER, on a return with the queue non-empty), RETURN (HANDLER to USER, on a return with the queue empty) and BURN (any state to HALT, on overflow).

Top module: `intq_dispatch`

## Requirements
- R1: While the handler-address register reads zero, arriving interrupts are discarded. Writing zero to that register empties the queue, so the queue is always empty while the address is zero.
- R2: A software interrupt and a hardware interrupt arriving in the same cycle are both queued, with the software message ahead of the hardware one.
- R3: Messages are dispatched in the order they entered the queue.
- R4: Entry happens only in a cycle where `insn_boundary` is high, `hold_value` is zero and the queue is non-empty, or on a return with the queue non-empty. `take` is high for exactly the next cycle, with `take_msg` set to the head message and `take_addr` set to the address register.
- R5: Entering a handler sets the hold word to 1.
- R6: `rfi` clears the hold word. If the queue is non-empty, the next message is entered in the following cycle with no boundary needed, and the hold word reads 1 again.
- R7: `hold_value` always shows the current hold word. A `hold_swap` loads `hold_wdata` at the clock edge, so during the swap cycle `hold_value` returns the old value.
- R8: A software interrupt raised while the hold word is nonzero is queued and not entered at a boundary. It runs only after the hold word returns to zero.
- R9: A queue holding exactly DEPTH messages is legal. A push beyond DEPTH, including two pushes at DEPTH-1, sets `hcf`. `hcf` stays high until reset, and after it no further `take` occurs.
- R10: After reset, `take`, `hcf`, `hold_value` and `ia_value` are all zero and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_valid | input | 1 | Hardware interrupt arrives this cycle |
| hw_msg | input | 16 | Hardware interrupt message |
| sw_valid | input | 1 | Software interrupt raised this cycle |
| sw_msg | input | 16 | Software interrupt message |
| insn_boundary | input | 1 | Core is between instructions |
| rfi | input | 1 | Core executes return-from-interrupt |
| hold_swap | input | 1 | Exchange the hold word with hold_wdata |
| hold_wdata | input | 16 | New hold word value |
| ia_wr | input | 1 | Write the handler-address register |
| ia_wdata | input | 16 | New handler address |
| take | output | 1 | One-cycle handler entry pulse |
| take_msg | output | 16 | Message of the entered interrupt |
| take_addr | output | 16 | Handler address for the entry |
| hold_value | output | 16 | Current hold word |
| ia_value | output | 16 | Current handler address |
| hcf | output | 1 | Halt after queue overflow |

## Verification
Two situations are the hardest to reach from the ports. The first is an overflow caused by two pushes in one cycle when the queue is one short of full. The second is the chained entry on a return, where no boundary is involved. The bench reaches both by building with a four-entry queue and raising the hold word so the queue fills without draining. It sweeps fill levels from empty to full, releases the hold and drains by returns, comparing each entry with a model queue of arithmetically generated messages.

// File: rtl/intq_pkg.sv
package intq_pkg;
    typedef enum logic [1:0] {
        ST_USER    = 2'd0,
        ST_HANDLER = 2'd1,
        ST_HALT    = 2'd2
    } intq_state_t;
endpackage

// File: rtl/intq_fifo.sv
module intq_fifo #(
    parameter int DEPTH = 256,
    parameter int W     = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int NW   = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_a,
    input  logic [W-1:0]  data_a,
    input  logic          push_b,
    input  logic [W-1:0]  data_b,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          overflow
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic [NW-1:0] cnt_nxt;
    logic [1:0]    n_push;
    logic [AW-1:0] addr_b;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] p, input logic [1:0] n);
        logic [AW+1:0] s;
        s = {2'b00, p} + (AW+2)'(n);
        if (s >= (AW+2)'(DEPTH))
            s = s - (AW+2)'(DEPTH);
        return s[AW-1:0];
    endfunction

    always_comb begin
        n_push   = {1'b0, push_a} + {1'b0, push_b};
        cnt_nxt  = NW'(cnt_q) + NW'(n_push) - NW'(pop);
        overflow = cnt_nxt > NW'(DEPTH);
        addr_b   = push_a ? adv(wp_q, 2'd1) : wp_q;
    end

    always_ff @(posedge clk) begin
        if (!flush && !overflow) begin
            if (push_a) mem[wp_q]   <= data_a;
            if (push_b) mem[addr_b] <= data_b;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (!overflow) begin
            wp_q  <= adv(wp_q, n_push);
            rp_q  <= adv(rp_q, {1'b0, pop});
            cnt_q <= cnt_nxt[CW-1:0];
        end
    end

    assign head  = mem[rp_q];
    assign count = cnt_q;
endmodule

// File: rtl/intq_ctrl.sv
module intq_ctrl
    import intq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         insn_boundary,
    input  logic         rfi,
    input  logic         hold_swap,
    input  logic [W-1:0] hold_wdata,
    input  logic         ia_wr,
    input  logic [W-1:0] ia_wdata,
    input  logic         q_empty,
    input  logic         q_overflow,
    input  logic [W-1:0] q_head,
    output logic         accept,
    output logic         flush,
    output logic         pop,
    output logic         take,
    output logic [W-1:0] take_msg,
    output logic [W-1:0] take_addr,
    output logic [W-1:0] hold_value,
    output logic [W-1:0] ia_value,
    output logic         hcf
);
    intq_state_t state_q, state_d;
    logic [W-1:0] hold_q, ia_q;
    logic         go, enter, hold_clear;

    always_comb begin
        flush  = ia_wr && (ia_wdata == '0);
        accept = (ia_q != '0) && (state_q != ST_HALT);
        go     = (state_q != ST_HALT) && !flush && !q_empty
                 && ((insn_boundary && hold_q == '0) || rfi);
        pop    = go;
        enter  = go && !q_overflow;
        hold_clear = rfi;
    end

    // next state: ENTER, CHAIN, RETURN, BURN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_USER: begin
                if (q_overflow)  state_d = ST_HALT;
                else if (enter)  state_d = ST_HANDLER;
            end
            ST_HANDLER: begin
                if (q_overflow)            state_d = ST_HALT;
                else if (rfi && !enter)    state_d = ST_USER;
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_USER;
        else        state_q <= state_d;
    end

    // registered outputs and architectural words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take      <= 1'b0;
            take_msg  <= '0;
            take_addr <= '0;
            hold_q    <= '0;
            ia_q      <= '0;
        end else begin
            take <= enter;
            if (enter) begin
                take_msg  <= q_head;
                take_addr <= ia_q;
            end
            if (enter)           hold_q <= W'(1);
            else if (hold_clear) hold_q <= '0;
            else if (hold_swap)  hold_q <= hold_wdata;
            if (ia_wr) ia_q <= ia_wdata;
        end
    end

    assign hold_value = hold_q;
    assign ia_value   = ia_q;
    assign hcf        = (state_q == ST_HALT);
endmodule

// File: rtl/intq_dispatch.sv
module intq_dispatch #(
    parameter int DEPTH = 256,
    parameter int W     = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hw_valid,
    input  logic [W-1:0] hw_msg,
    input  logic         sw_valid,
    input  logic [W-1:0] sw_msg,
    input  logic         insn_boundary,
    input  logic         rfi,
    input  logic         hold_swap,
    input  logic [W-1:0] hold_wdata,
    input  logic         ia_wr,
    input  logic [W-1:0] ia_wdata,
    output logic         take,
    output logic [W-1:0] take_msg,
    output logic [W-1:0] take_addr,
    output logic [W-1:0] hold_value,
    output logic [W-1:0] ia_value,
    output logic         hcf
);
    logic          accept, flush, pop, q_overflow;
    logic [W-1:0]  q_head;
    logic [CW-1:0] q_count;

    intq_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push_a   (sw_valid && accept),
        .data_a   (sw_msg),
        .push_b   (hw_valid && accept),
        .data_b   (hw_msg),
        .pop      (pop),
        .head     (q_head),
        .count    (q_count),
        .overflow (q_overflow)
    );

    intq_ctrl #(.W(W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .insn_boundary (insn_boundary),
        .rfi           (rfi),
        .hold_swap     (hold_swap),
        .hold_wdata    (hold_wdata),
        .ia_wr         (ia_wr),
        .ia_wdata      (ia_wdata),
        .q_empty       (q_count == '0),
        .q_overflow    (q_overflow),
        .q_head        (q_head),
        .accept        (accept),
        .flush         (flush),
        .pop           (pop),
        .take          (take),
        .take_msg      (take_msg),
        .take_addr     (take_addr),
        .hold_value    (hold_value),
        .ia_value      (ia_value),
        .hcf           (hcf)
    );
endmodule

// File: rtl/intq_checker.sv
module intq_checker #(
    parameter int DEPTH = 256,
    parameter int W     = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          insn_boundary,
    input logic          rfi,
    input logic          take,
    input logic          hcf,
    input logic [W-1:0]  hold_value,
    input logic [W-1:0]  ia_value,
    input logic [CW-1:0] q_count
);
    // R9
    hcf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) hcf |=> hcf);
    // R9
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) q_count <= CW'(DEPTH));
    // R4
    take_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(insn_boundary || rfi));
    // R5
    entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) take |-> hold_value != '0);
    // R6
    rfi_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfi |=> (take || hold_value == '0));
    // R1
    ia_zero_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ia_value == '0) |-> (q_count == '0));
endmodule

bind intq_dispatch intq_checker #(.DEPTH(DEPTH), .W(W)) u_intq_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_boundary (insn_boundary),
    .rfi           (rfi),
    .take          (take),
    .hcf           (hcf),
    .hold_value    (hold_value),
    .ia_value      (ia_value),
    .q_count       (q_count)
);

// File: tb/test_intq_dispatch.sv
module test_intq_dispatch;
    localparam int DEPTH = 4;
    localparam int W     = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hw_valid = 1'b0, sw_valid = 1'b0;
    logic [W-1:0] hw_msg = '0, sw_msg = '0;
    logic         insn_boundary = 1'b0, rfi = 1'b0, hold_swap = 1'b0, ia_wr = 1'b0;
    logic [W-1:0] hold_wdata = '0, ia_wdata = '0;
    logic         take, hcf;
    logic [W-1:0] take_msg, take_addr, hold_value, ia_value;

    int n_chk = 0;
    int n_err = 0;
    logic [W-1:0] mq [DEPTH + 2];
    int mq_n = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    intq_dispatch #(.DEPTH(DEPTH), .W(W)) i_intq_dispatch (
        .clk(clk), .rst_n(rst_n),
        .hw_valid(hw_valid), .hw_msg(hw_msg),
        .sw_valid(sw_valid), .sw_msg(sw_msg),
        .insn_boundary(insn_boundary), .rfi(rfi),
        .hold_swap(hold_swap), .hold_wdata(hold_wdata),
        .ia_wr(ia_wr), .ia_wdata(ia_wdata),
        .take(take), .take_msg(take_msg), .take_addr(take_addr),
        .hold_value(hold_value), .ia_value(ia_value), .hcf(hcf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
        mq_n = 0;
    endtask

    task automatic set_ia(input logic [W-1:0] v);
        ia_wr = 1'b1; ia_wdata = v;
        cyc();
        ia_wr = 1'b0;
        chk("R1 ia write", ia_value, v);
    endtask

    task automatic swap(input logic [W-1:0] v, input logic [W-1:0] old);
        hold_swap = 1'b1; hold_wdata = v;
        chk("R7 swap returns old", hold_value, old);
        cyc();
        hold_swap = 1'b0;
        chk("R7 swap loads new", hold_value, v);
    endtask

    task automatic raise(input bit sw, input bit hw, input logic [W-1:0] ms, input logic [W-1:0] mh);
        sw_valid = sw; sw_msg = ms; hw_valid = hw; hw_msg = mh;
        cyc();
        sw_valid = 1'b0; hw_valid = 1'b0;
        if (ia_value != '0) begin
            if (sw) begin mq[mq_n] = ms; mq_n++; end
            if (hw) begin mq[mq_n] = mh; mq_n++; end
        end
    endtask

    task automatic expect_take(input string req, input bit exp_take);
        chk(req, take, exp_take);
        if (exp_take && mq_n > 0) begin
            chk(req, take_msg, mq[0]);
            chk("R4 handler address", take_addr, ia_value);
            chk("R5 hold set on entry", hold_value, 1);
            for (int i = 1; i < mq_n; i++) mq[i-1] = mq[i];
            mq_n--;
        end
    endtask

    task automatic at_boundary(input string req, input bit exp_take);
        insn_boundary = 1'b1;
        cyc();
        insn_boundary = 1'b0;
        expect_take(req, exp_take);
    endtask

    task automatic do_rfi(input string req, input bit exp_take);
        rfi = 1'b1;
        cyc();
        rfi = 1'b0;
        expect_take(req, exp_take);
        if (!exp_take) chk("R6 rfi clears hold", hold_value, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R10 reset state
        chk("R10 take", take, 0);
        chk("R10 hcf", hcf, 0);
        chk("R10 hold", hold_value, 0);
        chk("R10 ia", ia_value, 0);

        // R1 drop while address is zero
        raise(1'b0, 1'b1, 16'h0, 16'h0bad);
        set_ia(16'h1234);
        at_boundary("R1 dropped when ia zero", 1'b0);

        // R2 same-cycle arrivals, software first; R4 only at boundary
        raise(1'b1, 1'b1, 16'h0007, 16'h0009);
        cyc();
        chk("R4 no take without boundary", take, 0);
        at_boundary("R2 software first", 1'b1);
        cyc();
        chk("R4 take is one cycle", take, 0);
        at_boundary("R8 held boundary no entry", 1'b0);
        do_rfi("R6 chained entry", 1'b1);
        do_rfi("R6 return empty", 1'b0);

        // R8 software interrupts under hold, R3 order after release
        swap(16'h0001, 16'h0000);
        raise(1'b1, 1'b0, 16'h0001, 16'h0);
        raise(1'b1, 1'b0, 16'h0002, 16'h0);
        raise(1'b1, 1'b0, 16'h0003, 16'h0);
        at_boundary("R8 queued not run", 1'b0);
        swap(16'h0005, 16'h0001);
        swap(16'h0000, 16'h0005);
        at_boundary("R3 first", 1'b1);
        do_rfi("R3 second", 1'b1);
        do_rfi("R3 third", 1'b1);
        do_rfi("R6 drained", 1'b0);

        // R3 sweep over fill levels 0..DEPTH (R9 exact full is legal)
        for (int n = 0; n <= DEPTH; n++) begin
            swap(16'h0001, 16'h0000);
            for (int i = 0; i < n; i++)
                raise(i[0] == 1'b0, i[0] == 1'b1, W'(16'h100 + n * 8 + i), W'(16'h100 + n * 8 + i));
            chk("R9 full is legal", hcf, 0);
            swap(16'h0000, 16'h0001);
            at_boundary("R3 sweep head", n > 0);
            for (int i = 1; i < n; i++) do_rfi("R3 sweep order", 1'b1);
            if (n > 0) do_rfi("R6 sweep end", 1'b0);
        end

        // R1 writing zero empties the queue
        swap(16'h0001, 16'h0000);
        raise(1'b1, 1'b1, 16'h0a0a, 16'h0b0b);
        set_ia(16'h0000);
        set_ia(16'h0777);
        mq_n = 0;
        swap(16'h0000, 16'h0001);
        at_boundary("R1 flushed by zero address", 1'b0);

        // R9 dual push at DEPTH-1 overflows
        swap(16'h0001, 16'h0000);
        for (int i = 0; i < DEPTH - 1; i++) raise(1'b1, 1'b0, W'(i), 16'h0);
        chk("R9 below full", hcf, 0);
        raise(1'b1, 1'b1, 16'h00ee, 16'h00ff);
        chk("R9 dual overflow", hcf, 1);

        do_reset();
        chk("R10 hcf cleared", hcf, 0);
        set_ia(16'h4000);
        swap(16'h0001, 16'h0000);
        for (int i = 0; i < DEPTH; i++) raise(1'b0, 1'b1, W'(i + 32), 16'h0 + W'(i + 32));
        chk("R9 exactly full", hcf, 0);
        raise(1'b1, 1'b0, 16'h0099, 16'h0);
        chk("R9 single overflow", hcf, 1);
        swap(16'h0000, 16'h0001);
        insn_boundary = 1'b1;
        cyc();
        insn_boundary = 1'b0;
        chk("R9 no entry after halt", take, 0);
        cyc();
        chk("R9 halt sticky", hcf, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule